// File: doc/BRIEF.md
# Serial Output-Expander Reset Sequencer

This block controls an external 8-bit serial-in, parallel-out shift register that has a storage latch. The latched outputs of that register drive board-level reset, standby and power-down lines. The block uses three wires to reach the register: a serial data line, a shift clock and a storage clock. A fourth wire is the active-low output enable. Each output position has a fixed role, and every role has a level for the first frame and a level for the second frame. A run shifts one complete frame into the register and latches it, then shifts and latches the second frame straight after. The device sees its reset line move through its two levels, while enable and disable lines settle directly at their final level.

There are two commands. A start command plays the two-frame pattern on all eight outputs. A pulse command targets one output, chosen by an index: only that output takes its first-frame level in frame one, and every other output holds its frame-two level in both frames. Every clock phase lasts a parameterised number of cycles, which stands in for a nominal half-period of 500 microseconds. While a run is in progress, `busy_o` is high. A one-cycle `done_o` marks the final latch edge.

Top module: `iox_seq`

## Requirements
- R1: Out of reset and between runs: `shclk_o`=1, `stclk_o`=1, `oe_o`=1, `sdata_o`=0, `busy_o`=0, `done_o`=0.
- R2: Output roles are Q0 reset, Q1 reset, Q2 reset, Q3 enable, Q4 disable, Q5 reset, Q6 disable, Q7 enable. The (frame one, frame two) levels are reset=(0,1), enable=(1,1), disable=(0,0). A start run therefore latches the word 0x88 and then the word 0xAF, where word bit i is Q i.
- R3: Inside a frame, the bit for Q7 is shifted first and the bit for Q0 last. `sdata_o` is stable across every rising edge of `shclk_o`.
- R4: Each low phase of `shclk_o` lasts exactly DELAY_CYC cycles. So does each high phase between two bits of the same frame, and so does each low phase of `stclk_o`. `stclk_o` is low only while `shclk_o` is high.
- R5: `oe_o` goes low in the first cycle after a command is accepted and stays low through the final latch cycle. It returns high in the cycle that follows.
- R6: For a pulse command with index k in 0..7, frame one is 0xAF with bit k replaced by the frame-one level of Q k, and frame two is 0xAF.
- R7: A pulse command with an index in 8..15 produces the same two words as a start run.
- R8: `busy_o` is high for exactly 34*DELAY_CYC+2 cycles per run, starting in the cycle after acceptance.
- R9: `start_i` and `pulse_i` are ignored while `busy_o` is high. The latched words and the run length do not change.
- R10: `done_o` is high for exactly one cycle per run. That cycle is the one in which `stclk_o` rises for the second latch.
- R11: The index is captured when the command is accepted. Later changes to `index_i` have no effect on the run.
- R12: When `start_i` and `pulse_i` are both high in the accepting cycle, the run is a start run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a full two-frame run |
| pulse_i | input | 1 | Request a single-output pulse run |
| index_i | input | IDX_W | Target output for a pulse run |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle marker of the final latch edge |
| sdata_o | output | 1 | Serial data to the shift register |
| shclk_o | output | 1 | Shift clock |
| stclk_o | output | 1 | Storage (latch) clock |
| oe_o | output | 1 | Output enable, active low |

## Verification
If the bit counter or the frame flag is corrupted, the word captured at the storage clock edge is wrong. The error can be seen as a word mismatch within one frame, which is at most 17*DELAY_CYC+1 cycles. If the delay timer is wrong, a clock phase comes out the wrong length, and this shows at the next edge of `shclk_o` or `stclk_o`. If the captured index or the mode bit is wrong, a pulse run latches the full-run word, or the reverse. The bench sweeps every index value, both commands and their overlap. It rebuilds the latched words from the pin activity alone.

// File: rtl/iox_pkg.sv
package iox_pkg;

  typedef enum logic [1:0] {
    ROLE_RST,
    ROLE_EN,
    ROLE_DIS
  } role_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SH_LO,
    ST_SH_HI,
    ST_LT_LO,
    ST_LT_HI
  } state_e;

  function automatic role_e role_of(input int idx);
    case (idx)
      3, 7:    return ROLE_EN;
      4, 6:    return ROLE_DIS;
      default: return ROLE_RST;
    endcase
  endfunction

  // second=0 -> frame one level, second=1 -> frame two level
  function automatic logic role_level(input role_e r, input logic second);
    case (r)
      ROLE_RST: return second;
      ROLE_EN:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/iox_timer.sv
module iox_timer #(
  parameter int DELAY_CYC = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expire_o
);
  localparam int CW = $clog2(DELAY_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = (cnt_q == CW'(DELAY_CYC - 1));

endmodule

// File: rtl/iox_pattern.sv
module iox_pattern
  import iox_pkg::*;
#(
  parameter int N_OUT = 8,
  localparam int BIT_W = $clog2(N_OUT)
) (
  input  logic             frame_i,
  input  logic             single_i,
  input  logic [BIT_W-1:0] sel_i,
  input  logic [BIT_W-1:0] bit_i,
  output logic             data_o
);
  logic [N_OUT-1:0] lvl;

  for (genvar g = 0; g < N_OUT; g++) begin : g_lvl
    logic use_first;
    assign use_first = !frame_i && (!single_i || (sel_i == BIT_W'(g)));
    assign lvl[g] = role_level(role_of(g), !use_first);
  end

  assign data_o = lvl[bit_i];

endmodule

// File: rtl/iox_ctrl.sv
module iox_ctrl
  import iox_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int IDX_W = 4,
  localparam int BIT_W = $clog2(N_OUT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pulse_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic             expire_i,
  output logic             restart_o,
  output state_e           state_o,
  output logic             frame_o,
  output logic             single_o,
  output logic [BIT_W-1:0] sel_o,
  output logic [BIT_W-1:0] bit_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(N_OUT - 1);

  state_e           state_q, state_d;
  logic             frame_q, frame_d;
  logic             single_q, single_d;
  logic [BIT_W-1:0] sel_q, sel_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && (start_i || pulse_i);

  always_comb begin
    state_d  = state_q;
    frame_d  = frame_q;
    single_d = single_q;
    sel_d    = sel_q;
    bit_d    = bit_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = ST_SH_LO;
        frame_d  = 1'b0;
        bit_d    = LAST_BIT;
        // start wins over pulse; out-of-range index degrades to full run
        single_d = !start_i && (index_i < IDX_W'(N_OUT));
        sel_d    = index_i[BIT_W-1:0];
      end
      ST_SH_LO: if (expire_i) state_d = ST_SH_HI;
      ST_SH_HI: if (expire_i) begin
        if (bit_q == '0) state_d = ST_LT_LO;
        else begin
          state_d = ST_SH_LO;
          bit_d   = bit_q - 1'b1;
        end
      end
      ST_LT_LO: if (expire_i) state_d = ST_LT_HI;
      ST_LT_HI: begin
        if (!frame_q) begin
          state_d = ST_SH_LO;
          frame_d = 1'b1;
          bit_d   = LAST_BIT;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      frame_q  <= 1'b0;
      single_q <= 1'b0;
      sel_q    <= '0;
      bit_q    <= '0;
    end else begin
      state_q  <= state_d;
      frame_q  <= frame_d;
      single_q <= single_d;
      sel_q    <= sel_d;
      bit_q    <= bit_d;
    end
  end

  assign restart_o = (state_d != state_q);
  assign state_o   = state_q;
  assign frame_o   = frame_q;
  assign single_o  = single_q;
  assign sel_o     = sel_q;
  assign bit_o     = bit_q;

endmodule

// File: rtl/iox_seq.sv
module iox_seq
  import iox_pkg::*;
#(
  parameter int N_OUT     = 8,
  parameter int IDX_W     = 4,
  parameter int DELAY_CYC = 50000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pulse_i,
  input  logic [IDX_W-1:0] index_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sdata_o,
  output logic             shclk_o,
  output logic             stclk_o,
  output logic             oe_o
);
  localparam int BIT_W = $clog2(N_OUT);

  state_e           state;
  logic             frame, single, restart, expire, pat_bit;
  logic [BIT_W-1:0] sel, bit_idx;

  iox_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .expire_o  (expire)
  );

  iox_ctrl #(.N_OUT(N_OUT), .IDX_W(IDX_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .pulse_i   (pulse_i),
    .index_i   (index_i),
    .expire_i  (expire),
    .restart_o (restart),
    .state_o   (state),
    .frame_o   (frame),
    .single_o  (single),
    .sel_o     (sel),
    .bit_o     (bit_idx)
  );

  iox_pattern #(.N_OUT(N_OUT)) u_pat (
    .frame_i  (frame),
    .single_i (single),
    .sel_i    (sel),
    .bit_i    (bit_idx),
    .data_o   (pat_bit)
  );

  assign busy_o  = (state != ST_IDLE);
  assign done_o  = (state == ST_LT_HI) && frame;
  assign shclk_o = (state != ST_SH_LO);
  assign stclk_o = (state != ST_LT_LO);
  assign oe_o    = (state == ST_IDLE);
  assign sdata_o = ((state == ST_SH_LO) || (state == ST_SH_HI)) ? pat_bit : 1'b0;

endmodule

// File: rtl/iox_seq_chk.sv
module iox_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             pulse_i,
  input logic [IDX_W-1:0] index_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             sdata_o,
  input logic             shclk_o,
  input logic             stclk_o,
  input logic             oe_o
);
  // R1
  idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (shclk_o && stclk_o && oe_o && !sdata_o && !done_o));

  // R3
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shclk_o) |-> $stable(sdata_o));

  // R4
  latch_clk_sep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stclk_o |-> shclk_o);

  // R5
  oe_low_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !oe_o);

  // R5
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (oe_o && !busy_o));

  // R10
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  done_on_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(stclk_o));

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

endmodule

bind iox_seq iox_seq_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/iox_seq_bench.sv
module iox_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 3;
  localparam int RUN_LEN    = 34 * D + 2;
  localparam int ROLE [8]   = '{0, 0, 0, 1, 2, 0, 2, 1}; // 0 reset 1 enable 2 disable

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, pulse = 1'b0;
  logic [3:0] index = '0;
  logic       busy, done, sdata, shclk, stclk, oe;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iox_seq #(.N_OUT(8), .IDX_W(4), .DELAY_CYC(D)) u_iox_seq (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .pulse_i (pulse),
    .index_i (index), .busy_o (busy), .done_o (done), .sdata_o (sdata),
    .shclk_o (shclk), .stclk_o (stclk), .oe_o (oe)
  );

  // pin monitor
  logic [7:0] sr = '0, lat0 = '0, lat1 = '0;
  logic prev_sh = 1'b1, prev_st = 1'b1;
  int sh_run = 0, st_run = 0, bit_mod = 0;
  int n_lat = 0, busy_cnt = 0, done_cnt = 0, oe_bad = 0, tim_bad = 0, done_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (busy) busy_cnt++;
    if (busy && oe) oe_bad++;
    if (shclk != prev_sh) begin
      if (shclk) begin
        if (sh_run != D) tim_bad++;
        sr = {sr[6:0], sdata};
        bit_mod = (bit_mod + 1) % 8;
      end else if (bit_mod != 0 && sh_run != D) tim_bad++;
      sh_run = 1;
    end else sh_run++;
    if (stclk != prev_st) begin
      if (stclk) begin
        if (st_run != D) tim_bad++;
        lat0 = lat1; lat1 = sr; n_lat++;
      end
      st_run = 1;
    end else st_run++;
    if (done) begin
      done_cnt++;
      if (!(stclk && !prev_st)) done_bad++;
    end
    prev_sh = shclk;
    prev_st = stclk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit lvl(input int i, input int f);
    return (ROLE[i] == 0) ? f[0] : (ROLE[i] == 1);
  endfunction

  task automatic run_cmd(input bit s, input bit p, input logic [3:0] idx, input bit disturb);
    logic [7:0] e1, e2;
    int b_lat, b_busy, b_done, b_oe, b_tim, b_db, waited;
    bit single;
    single = !s && p && (idx < 8);
    for (int i = 0; i < 8; i++) begin
      e2[i] = lvl(i, 1);
      e1[i] = (single && idx != i[3:0]) ? lvl(i, 1) : lvl(i, 0);
    end
    b_lat = n_lat; b_busy = busy_cnt; b_done = done_cnt;
    b_oe = oe_bad; b_tim = tim_bad; b_db = done_bad;
    @(negedge clk); start = s; pulse = p; index = idx;
    @(negedge clk); start = 0; pulse = 0; index = idx ^ 4'h5; // R11
    check(busy && !oe, "R5/R8 first cycle busy, oe low", {busy, oe}, 2'b10);
    if (disturb) begin
      repeat (20) @(negedge clk);
      start = 1; pulse = 1; index = ~idx; // R9
      @(negedge clk); start = 0; pulse = 0;
      repeat (40) @(negedge clk);
      start = 1;
      @(negedge clk); start = 0;
    end
    waited = 0;
    while (busy && waited < 40 * D + 60) begin
      @(negedge clk); waited++;
    end
    check(!busy, "R8 run terminates", busy, 0);
    check(n_lat - b_lat == 2, "R2 two latches", n_lat - b_lat, 2);
    check(lat0 == e1, single ? "R6 frame one" : "R2/R3/R7/R9/R11/R12 frame one", lat0, e1);
    check(lat1 == e2, single ? "R6 frame two" : "R2/R3/R7/R9/R11/R12 frame two", lat1, e2);
    check(busy_cnt - b_busy == RUN_LEN, "R8/R9 busy length", busy_cnt - b_busy, RUN_LEN);
    check(done_cnt - b_done == 1, "R10 one done", done_cnt - b_done, 1);
    check(done_bad == b_db, "R10 done on final latch edge", done_bad - b_db, 0);
    check(oe_bad == b_oe, "R5 oe low while busy", oe_bad - b_oe, 0);
    check(tim_bad == b_tim, "R4 phase lengths", tim_bad - b_tim, 0);
    check(shclk && stclk && oe && !sdata && !done, "R1/R5 idle lines after run",
          {shclk, stclk, oe, sdata, done}, 5'b11100);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(shclk && stclk && oe && !sdata && !busy && !done, "R1 reset state",
          {shclk, stclk, oe, sdata, busy, done}, 6'b111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(shclk && stclk && oe && !sdata && !busy, "R1 idle after reset",
          {shclk, stclk, oe, sdata, busy}, 5'b11100);
    run_cmd(1, 0, 4'd0, 0);                              // R2 R3
    for (int k = 0; k < 8; k++) run_cmd(0, 1, 4'(k), 0);  // R6
    for (int k = 8; k < 16; k++) run_cmd(0, 1, 4'(k), 0); // R7
    run_cmd(1, 1, 4'd3, 0);                              // R12
    run_cmd(0, 1, 4'd5, 1);                              // R9
    run_cmd(1, 0, 4'd9, 1);                              // R9
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule